// File: doc/BRIEF.md
# Serial Port Register Front End with Armed Flag Clearing

This block is the software-visible side of a UART-style serial port. It holds a 16-bit status register whose flags are raised by one-cycle pulses from the receive and transmit cores. It also holds a control register with one interrupt enable per flag and a 9-bit data mode switch. A single data address carries two registers. Reads there return the receive holding register. Writes there load the transmit holding register, which is then offered to the transmit shifter with a one-cycle load strobe.

No flag can be cleared by writing to it. Software first reads the status register. That read arms the clear for exactly the flags that were set at that moment, bit by bit. A later access to the data address then clears the armed flags that match its kind: a data read clears armed receive flags, and a data write clears armed transmit flags. A flag raised after the arming read is not armed, so it survives the access. A long read fetches status and data in one access and clears only the receive flags that were set at that instant.

Top module: `fx_serial_regs`

## Requirements
- R1: After reset every flag, every armed bit, the control register, the receive register and the transmit register are zero, `tx_load` is low and `irq` is zero.
- R2: A pulse on `set_pulse[i]` sets flag i from the next cycle. The status word places receive flags 0..5 at bits 0..5, the transmit-empty flag (index 6) at bit 8, the transmit-done flag (index 7) at bit 9, and zero in every other bit. A status read at address 1 returns it in `bus_rdata[15:0]`.
- R3: A status read followed by a data read (address 2) clears the receive flags that were set at the status read. Transmit flags are left as they are.
- R4: A status read followed by a data write (address 2) clears the transmit flags that were set at the status read. Receive flags are left as they are.
- R5: A flag set after the status read is not cleared by the following data access. It clears only after a new status read and another matching access.
- R6: A status read with either byte enable alone arms every set flag of the full 16-bit word.
- R7: A long read (`bus_long` high at address 1) returns status in bits 31:16 and the data value in bits 15:0. It clears the receive flags set at that moment and leaves both transmit flags set.
- R8: When a set pulse and a clear hit the same flag in one cycle, the flag stays set.
- R9: A data read returns the receive register. A data write loads the transmit register and raises `tx_load` for exactly the next cycle, with `tx_word` holding the value.
- R10: With mode bit clear (8-bit mode), bit 8 of a written word is dropped and bit 8 of a data read is zero. With it set (9-bit mode), bit 8 is carried both ways.
- R11: A control write at address 0 sets the enable mask from `bus_wdata[7:0]` when byte enable 0 is high, and the mode bit from `bus_wdata[8]` when byte enable 1 is high. `irq[i]` equals flag i AND enable i.
- R12: A data access with no armed flags clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_be | input | 2 | Byte enables; an access needs at least one |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_long | input | 1 | Long read of status plus data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| set_pulse | input | 8 | Flag set pulses from the cores |
| rx_load | input | 1 | Receive core delivers a word |
| rx_word | input | 9 | Received word |
| tx_load | output | 1 | Transmit register loaded, one cycle |
| tx_word | output | 9 | Transmit register contents |
| irq | output | 8 | Per-flag interrupt requests |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The bench samples it one nanosecond after driving, well before the edge. Flag changes, armed state, control values and `irq` appear one edge after the causing access or pulse. `tx_load` and `tx_word` also appear after one edge. The bench updates its model at each rising edge and compares `irq`, `tx_load` and `tx_word` at the following falling edge, so every result is checked in the first cycle it is due.

// File: rtl/fx_pkg.sv
package fx_pkg;
  parameter int NFLAG  = 8;
  parameter int NRX    = 6;
  parameter int DW     = 9;
  parameter int BUS_W  = 16;
  localparam int IDX_TXE = NRX;
  localparam int IDX_TXC = NRX + 1;
  localparam int POS_TXE = 8;
  localparam int POS_TXC = 9;

  function automatic logic [NFLAG-1:0] rx_mask();
    logic [NFLAG-1:0] m;
    m = '0;
    for (int i = 0; i < NRX; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(input logic [NFLAG-1:0] f);
    logic [BUS_W-1:0] s;
    s = '0;
    for (int i = 0; i < NRX; i++) s[i] = f[i];
    s[POS_TXE] = f[IDX_TXE];
    s[POS_TXC] = f[IDX_TXC];
    return s;
  endfunction

  function automatic logic [DW-1:0] fit_mode(input logic [DW-1:0] w, input logic nine);
    logic [DW-1:0] r;
    r = w;
    if (!nine) r[DW-1] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/fx_bus_decode.sv
module fx_bus_decode (
  input  logic [1:0] addr,
  input  logic [1:0] be,
  input  logic       rd,
  input  logic       wr,
  input  logic       lng,
  output logic       ctrl_wr_lo,
  output logic       ctrl_wr_hi,
  output logic       stat_rd,
  output logic       long_rd,
  output logic       data_rd,
  output logic       data_wr
);
  logic any_be;
  assign any_be     = |be;
  assign ctrl_wr_lo = wr && addr == 2'd0 && be[0];
  assign ctrl_wr_hi = wr && addr == 2'd0 && be[1];
  assign stat_rd    = rd && addr == 2'd1 && any_be && !lng;
  assign long_rd    = rd && addr == 2'd1 && any_be && lng;
  assign data_rd    = rd && addr == 2'd2 && any_be;
  assign data_wr    = wr && addr == 2'd2 && any_be;
endmodule

// File: rtl/fx_flag_bank.sv
module fx_flag_bank #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_rd,
  input  logic          long_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [NF-1:0] set_pulse,
  input  logic [NF-1:0] rxm,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] armed,
  output logic [NF-1:0] clr
);
  logic [NF-1:0] arm_n;

  always_comb begin
    clr   = '0;
    arm_n = armed;
    if (long_rd) begin
      clr   = flags & rxm;
      arm_n = flags & ~rxm;
    end else if (stat_rd) begin
      arm_n = flags;
    end
    if (data_rd) begin
      clr   = clr | (armed & rxm);
      arm_n = arm_n & ~rxm;
    end
    if (data_wr) begin
      clr   = clr | (armed & ~rxm);
      arm_n = arm_n & rxm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~clr) | set_pulse;
      armed <= arm_n;
    end
  end
endmodule

// File: rtl/fx_data_regs.sv
module fx_data_regs #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic [W-1:0] wdata,
  input  logic         nine,
  input  logic         rx_load,
  input  logic [W-1:0] rx_word,
  output logic [W-1:0] rd_val,
  output logic         tx_load,
  output logic [W-1:0] tx_word
);
  logic [W-1:0] rdr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdr     <= '0;
      tx_word <= '0;
      tx_load <= 1'b0;
    end else begin
      if (rx_load) rdr <= rx_word;
      if (data_wr) tx_word <= fx_pkg::fit_mode(wdata, nine);
      tx_load <= data_wr;
    end
  end

  assign rd_val = fx_pkg::fit_mode(rdr, nine);
endmodule

// File: rtl/fx_serial_regs.sv
module fx_serial_regs
  import fx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             bus_addr,
  input  logic [1:0]             bus_be,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic                   bus_long,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [2*BUS_W-1:0]     bus_rdata,
  input  logic [NFLAG-1:0]       set_pulse,
  input  logic                   rx_load,
  input  logic [DW-1:0]          rx_word,
  output logic                   tx_load,
  output logic [DW-1:0]          tx_word,
  output logic [NFLAG-1:0]       irq
);
  localparam logic [NFLAG-1:0] RXM = rx_mask();

  logic ctrl_wr_lo, ctrl_wr_hi, stat_rd, long_rd, data_rd, data_wr;
  logic [NFLAG-1:0] flags, armed, clr, enables;
  logic             mode9;
  logic [DW-1:0]    data_val;
  logic [BUS_W-1:0] status, data_word, ctrl_word;

  fx_bus_decode u_dec (
    .addr(bus_addr), .be(bus_be), .rd(bus_rd), .wr(bus_wr), .lng(bus_long),
    .ctrl_wr_lo(ctrl_wr_lo), .ctrl_wr_hi(ctrl_wr_hi), .stat_rd(stat_rd),
    .long_rd(long_rd), .data_rd(data_rd), .data_wr(data_wr)
  );

  fx_flag_bank #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .long_rd(long_rd),
    .data_rd(data_rd), .data_wr(data_wr), .set_pulse(set_pulse), .rxm(RXM),
    .flags(flags), .armed(armed), .clr(clr)
  );

  fx_data_regs #(.W(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(bus_wdata[DW-1:0]),
    .nine(mode9), .rx_load(rx_load), .rx_word(rx_word), .rd_val(data_val),
    .tx_load(tx_load), .tx_word(tx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables <= '0;
      mode9   <= 1'b0;
    end else begin
      if (ctrl_wr_lo) enables <= bus_wdata[NFLAG-1:0];
      if (ctrl_wr_hi) mode9   <= bus_wdata[8];
    end
  end

  assign status    = pack_status(flags);
  assign data_word = BUS_W'(data_val);
  assign ctrl_word = BUS_W'({mode9, enables});

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[BUS_W-1:0] = ctrl_word;
      2'd1: bus_rdata = bus_long ? {status, data_word} : {{BUS_W{1'b0}}, status};
      2'd2: bus_rdata[BUS_W-1:0] = data_word;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = flags & enables;
endmodule

// File: rtl/fx_serial_regs_chk.sv
module fx_serial_regs_chk
  import fx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NFLAG-1:0]     flags,
  input logic [NFLAG-1:0]     armed,
  input logic [NFLAG-1:0]     set_pulse,
  input logic                 long_rd,
  input logic                 data_rd,
  input logic                 data_wr,
  input logic                 tx_load,
  input logic                 mode9,
  input logic [2*BUS_W-1:0]   bus_rdata
);
  localparam logic [NFLAG-1:0] RXM = rx_mask();

  p_load_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> tx_load);

  p_no_stray_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !tx_load);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_pulse) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));

  p_clear_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !long_rd |=> ((($past(flags) & ~flags) & ~$past(armed)) == '0));

  p_rx_clear_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flags) & ~flags) & RXM) != '0) |-> $past(data_rd || long_rd));

  p_tx_clear_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(flags) & ~flags) & ~RXM) != '0) |-> $past(data_wr));

  p_mode8_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !mode9) |-> (bus_rdata[DW-1] == 1'b0));
endmodule

bind fx_serial_regs fx_serial_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .armed(armed), .set_pulse(set_pulse),
  .long_rd(long_rd), .data_rd(data_rd), .data_wr(data_wr), .tx_load(tx_load),
  .mode9(mode9), .bus_rdata(bus_rdata)
);

// File: tb/fx_serial_regs_test.sv
module fx_serial_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0, be = '0;
  logic        rd = 1'b0, wr = 1'b0, lng = 1'b0, rxl = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  setp = '0;
  logic [8:0]  rxw = '0;
  logic [31:0] rdata;
  logic        txl;
  logic [8:0]  txw;
  logic [7:0]  irq;

  int checks = 0, fails = 0;

  // behavioural model state
  bit  mf[8], ma[8];
  logic [7:0] men = '0;
  bit  mmode = 0, mtxl = 0;
  logic [8:0] mrdr = '0, mtdr = '0;

  always #5 clk = ~clk;

  fx_serial_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_be(be), .bus_rd(rd),
    .bus_wr(wr), .bus_long(lng), .bus_wdata(wdata), .bus_rdata(rdata),
    .set_pulse(setp), .rx_load(rxl), .rx_word(rxw), .tx_load(txl),
    .tx_word(txw), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = 0;
    for (int i = 0; i < 6; i++) if (mf[i]) s[i] = 1'b1;
    if (mf[6]) s[8] = 1'b1;
    if (mf[7]) s[9] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] m_data();
    return mmode ? 32'(mrdr) : 32'(mrdr[7:0]);
  endfunction

  function automatic logic [7:0] m_irq();
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) r[i] = mf[i] && men[i];
    return r;
  endfunction

  function automatic logic [31:0] m_read();
    case (addr)
      2'd0: return {23'b0, mmode, men};
      2'd1: return lng ? ((m_status() << 16) | m_data()) : m_status();
      2'd2: return m_data();
      default: return 0;
    endcase
  endfunction

  task automatic m_update();
    bit of[8], oa[8], clr[8];
    bit srd, drd, dwr;
    srd = rd && addr == 1 && be != 0;
    drd = rd && addr == 2 && be != 0;
    dwr = wr && addr == 2 && be != 0;
    for (int i = 0; i < 8; i++) begin of[i] = mf[i]; oa[i] = ma[i]; clr[i] = 0; end
    for (int i = 0; i < 8; i++) begin
      bit is_rx = (i < 6);
      if (srd && !lng) ma[i] = of[i];
      if (srd && lng) begin
        ma[i] = is_rx ? 0 : of[i];
        if (is_rx && of[i]) clr[i] = 1;
      end
      if (drd && is_rx) begin if (oa[i]) clr[i] = 1; ma[i] = 0; end
      if (dwr && !is_rx) begin if (oa[i]) clr[i] = 1; ma[i] = 0; end
      mf[i] = (of[i] && !clr[i]) || setp[i];
    end
    if (wr && addr == 0 && be[0]) men = wdata[7:0];
    if (wr && addr == 0 && be[1]) mmode = wdata[8];
    mtxl = dwr;
    if (dwr) mtdr = mmode ? wdata[8:0] : {1'b0, wdata[7:0]};
    if (rxl) mrdr = rxw;
  endtask

  // inputs placed by caller just after a falling edge
  task automatic tick(input string req);
    #1;
    if (rd) check(req, rdata, m_read());
    @(posedge clk);
    m_update();
    @(negedge clk);
    check({req, " irq"}, 32'(irq), 32'(m_irq()));
    check({req, " tx_load"}, 32'(txl), 32'(mtxl));
    check({req, " tx_word"}, 32'(txw), 32'(mtdr));
    rd = 0; wr = 0; lng = 0; be = 0; setp = 0; rxl = 0;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [1:0] b, input bit l,
                       input logic [7:0] sp, input string req);
    addr = a; be = b; rd = 1; lng = l; setp = sp; tick(req);
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [1:0] b,
                       input logic [15:0] d, input string req);
    addr = a; be = b; wr = 1; wdata = d; tick(req);
  endtask

  task automatic do_set(input logic [7:0] sp, input string req);
    setp = sp; tick(req);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mf[i] = 0; ma[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 tx_load", 32'(txl), 0);
    do_rd(2'd1, 2'b11, 0, 0, "R1 status");
    do_rd(2'd0, 2'b11, 0, 0, "R1 control");
    do_rd(2'd2, 2'b11, 0, 0, "R1 data");
    // R11: enable all, byte lane 0 only
    do_wr(2'd0, 2'b01, 16'h01FF, "R11 ctrl lo");
    do_rd(2'd0, 2'b11, 0, 0, "R11 ctrl readback");
    // R2: set rx_full and tx_empty
    rxw = 9'h05A; rxl = 1; do_set(8'h41, "R2 set");
    do_rd(2'd1, 2'b01, 0, 0, "R2 status");
    // status read above armed bits; clear arm by reading data (rx cleared)
    do_rd(2'd2, 2'b01, 0, 0, "R3 data read clears rx");
    do_rd(2'd1, 2'b11, 0, 0, "R3 tx kept");
    // R12: no arm -> no clear
    do_set(8'h01, "R12 set");
    do_rd(2'd2, 2'b11, 0, 0, "R12 data read unarmed");
    do_rd(2'd1, 2'b11, 0, 0, "R12 status");
    do_wr(2'd2, 2'b11, 16'h0011, "R4 write clears tx");
    do_rd(2'd1, 2'b11, 0, 0, "R4 rx kept");
    // R5: flag set after arming survives
    do_rd(2'd1, 2'b11, 0, 0, "R5 arm");
    do_set(8'h02, "R5 late set");
    do_rd(2'd2, 2'b11, 0, 0, "R5 access");
    do_rd(2'd1, 2'b11, 0, 0, "R5 survivor");
    do_rd(2'd2, 2'b11, 0, 0, "R5 second access");
    do_rd(2'd1, 2'b11, 0, 0, "R5 cleared");
    // R6: upper byte read arms rx flags in lower byte
    do_set(8'h0C, "R6 set");
    do_rd(2'd1, 2'b10, 0, 0, "R6 upper read");
    do_rd(2'd2, 2'b11, 0, 0, "R6 access");
    do_rd(2'd1, 2'b11, 0, 0, "R6 result");
    // R8: set wins over clear
    do_set(8'h10, "R8 set");
    do_rd(2'd1, 2'b11, 0, 0, "R8 arm");
    do_rd(2'd2, 2'b11, 0, 8'h10, "R8 clash");
    do_rd(2'd1, 2'b11, 0, 0, "R8 still set");
    // R7: long read
    do_set(8'hC1, "R7 set");
    do_rd(2'd1, 2'b01, 1, 0, "R7 long read");
    do_rd(2'd1, 2'b11, 0, 0, "R7 after long");
    // R10: 9-bit mode
    do_wr(2'd0, 2'b10, 16'h0100, "R10 mode9 on");
    rxw = 9'h1A5; rxl = 1; do_set(8'h00, "R10 rx load");
    do_rd(2'd2, 2'b11, 0, 0, "R10 nine-bit read");
    do_wr(2'd2, 2'b11, 16'h01C3, "R10 nine-bit write");
    do_wr(2'd0, 2'b10, 16'h0000, "R10 mode9 off");
    do_rd(2'd2, 2'b11, 0, 0, "R10 eight-bit read");
    do_wr(2'd2, 2'b11, 16'h01FF, "R9 R10 eight-bit write");
    // R11: partial enable mask
    do_wr(2'd0, 2'b01, 16'h0081, "R11 partial enables");
    do_set(8'hFF, "R11 irq mask");
    do_rd(2'd0, 2'b11, 0, 0, "R11 ctrl");
    repeat (2) do_set(8'h00, "R2 idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule